// File: doc/BRIEF.md
# Indirect Flash Read Buffer Controller

This block runs a long read from a serial flash into an on-chip word buffer. The host drains that buffer through a data window. Software first sets a byte count and a flash start address, then writes the start bit of the control word. The controller then pulls 32-bit words from the serial engine. That engine sits outside the block and appears here as a source with valid/ready. Each word goes into a FIFO, and the flash byte address rises by four per word.

The host polls a level register to see how many words are waiting. Each read strobe on the window removes one word. A partition register caps the share of the buffer that reads may fill. Fetching pauses at that cap and resumes once the host frees space. When the byte count is used up and the last word has left through the window, the controller drops its in-progress flag and raises a sticky done flag. The host clears done by writing one to it. A cancel stops the transfer at once, empties the buffer and leaves done untouched.

Top module: `ird_ctrl`

## Requirements
- R1: After reset the control word reads 0, the level register reads 0, the partition register reads DEPTH/2 (8 by default) and src_ready is low.
- R2: Register selects on host_sel are 0 control, 1 byte count, 2 flash start address, 3 level and 4 partition. A host write of control bit 0 while idle sets control bit 2 (in progress) from the next cycle and puts the start address on fl_addr.
- R3: A word is taken whenever src_valid and src_ready are both high, and fl_addr then rises by 4. Once ceil(count/4) words have been taken, src_ready stays low.
- R4: Level register bits 15:0 give the number of buffered words. Bits 31:16, the write-side level, always read 0.
- R5: A win_rd pulse while the level is nonzero removes the oldest word, which win_data shows beforehand (first in, first out). A win_rd pulse on an empty buffer changes nothing. A take and a removal in the same cycle leave the level unchanged.
- R6: When count is not a multiple of 4, the last word keeps its low count mod 4 bytes (byte 0 in bits 7:0) and has its upper bytes forced to zero.
- R7: src_ready is low while the level is at or above the partition value, and fetching resumes once a removal makes room. A partition write above DEPTH is stored as DEPTH.
- R8: When the last word is removed, control bit 2 clears and bit 5 (done) sets in the same cycle. Done stays set until a control write with bit 5 at one. If that write lands in the same cycle as the final removal, done stays set.
- R9: A control write with bit 1 (cancel) clears in progress, empties the buffer and drops src_ready in the next cycle, and does not set done. When a write sets both bit 0 and bit 1, cancel wins and no transfer starts.
- R10: A start while a transfer is in progress is ignored, and the running transfer keeps its address and count.
- R11: A start with a byte count of 0 sets done at once and never sets in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select for write and read |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_sel |
| win_rd | input | 1 | Data window read strobe, removes one word |
| win_data | output | 32 | Oldest buffered word |
| src_valid | input | 1 | Word from the serial engine is valid |
| src_data | input | 32 | Word from the serial engine |
| src_ready | output | 1 | Controller accepts a word this cycle |
| fl_addr | output | 32 | Flash byte address of the next word |

## Verification
A word can enter the buffer in the same cycle that the host removes one. Likewise, the final removal that sets done can coincide with a host write that clears done. The bench stops the source to hold three words, then raises src_valid and win_rd together for one cycle. It expects the level to stay at three and the removed word to be the oldest. It also issues the last removal of a transfer in the same cycle as a control write of bit 5, and expects done to read as set afterwards, because setting has priority over clearing.

// File: rtl/ird_pkg.sv
package ird_pkg;
    localparam int REG_W      = 32;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_LEVEL = 3'd3,
        SEL_PART  = 3'd4
    } reg_sel_e;

    localparam int CTL_GO    = 0;
    localparam int CTL_ABORT = 1;
    localparam int CTL_BUSY  = 2;
    localparam int CTL_DONE  = 5;

    typedef struct packed {
        logic go;
        logic abort;
        logic ack_done;
    } ctl_cmd_t;

    // bytes consumed by one word: four, or whatever is left
    function automatic logic [REG_W-1:0] take_bytes(input logic [REG_W-1:0] left);
        return (left >= REG_W'(WORD_BYTES)) ? REG_W'(WORD_BYTES) : left;
    endfunction

    // zero the bytes at and above index keep
    function automatic logic [REG_W-1:0] pad_word(input logic [REG_W-1:0] w,
                                                  input logic [2:0] keep);
        logic [REG_W-1:0] r;
        for (int b = 0; b < WORD_BYTES; b++)
            r[b*8 +: 8] = (b < int'(keep)) ? w[b*8 +: 8] : 8'h00;
        return r;
    endfunction
endpackage

// File: rtl/ird_buf.sv
module ird_buf
    import ird_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [REG_W-1:0] wdata,
    input  logic             pop,
    output logic [REG_W-1:0] rdata,
    output logic [LW-1:0]    level
);
    logic [REG_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             push_ok, pop_ok;

    assign push_ok = push && (level < LW'(DEPTH));
    assign pop_ok  = pop && (level != '0);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (level < LW'(DEPTH)));
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && level == '0 && !push && !flush) |=> (level == '0));
    a_r5_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (push && pop && level != '0 && level < LW'(DEPTH) && !flush) |=> $stable(level));
endmodule

// File: rtl/ird_seq.sv
module ird_seq
    import ird_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_cmd_t         cmd,
    input  logic [REG_W-1:0] count_q,
    input  logic [REG_W-1:0] addr_q,
    input  logic [LW-1:0]    level,
    input  logic [LW-1:0]    part,
    input  logic             src_valid,
    input  logic [REG_W-1:0] src_data,
    input  logic             win_rd,
    output logic             busy,
    output logic             done,
    output logic             src_ready,
    output logic [REG_W-1:0] fl_addr,
    output logic             push,
    output logic [REG_W-1:0] push_data,
    output logic             pop,
    output logic             flush
);
    logic [REG_W-1:0] fetch_left, drain_left, fetch_step, drain_step;
    logic             launch, final_pop, done_set;

    assign launch     = cmd.go && !cmd.abort && !busy;
    assign flush      = cmd.abort || launch;
    assign fetch_step = take_bytes(fetch_left);
    assign drain_step = take_bytes(drain_left);
    assign src_ready  = busy && !cmd.abort && (fetch_left != '0) && (level < part);
    assign push       = src_ready && src_valid;
    assign push_data  = pad_word(src_data, fetch_step[2:0]);
    assign pop        = win_rd && (level != '0) && !flush;
    assign final_pop  = pop && busy && (drain_left <= REG_W'(WORD_BYTES));
    assign done_set   = !cmd.abort && (final_pop || (launch && count_q == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            fetch_left <= '0;
            drain_left <= '0;
            fl_addr    <= '0;
        end else if (cmd.abort) begin
            busy       <= 1'b0;
            fetch_left <= '0;
            drain_left <= '0;
        end else if (launch) begin
            busy       <= (count_q != '0);
            fetch_left <= count_q;
            drain_left <= count_q;
            fl_addr    <= addr_q;
        end else begin
            if (push) begin
                fetch_left <= fetch_left - fetch_step;
                fl_addr    <= fl_addr + REG_W'(WORD_BYTES);
            end
            if (pop)       drain_left <= drain_left - drain_step;
            if (final_pop) busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               done <= 1'b0;
        else if (done_set)     done <= 1'b1;
        else if (cmd.ack_done) done <= 1'b0;
    end

    a_r9_cancel_clears: assert property (@(posedge clk) disable iff (rst)
        cmd.abort |=> (!busy && level == '0 && !src_ready));
    a_r9_cancel_no_done: assert property (@(posedge clk) disable iff (rst)
        (cmd.abort && !done) |=> !done);
    a_r7_stall: assert property (@(posedge clk) disable iff (rst)
        (level >= part) |-> !src_ready);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (final_pop && cmd.ack_done && !cmd.abort) |=> done);
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (push && !cmd.abort) |=> (fl_addr == $past(fl_addr) + REG_W'(WORD_BYTES)));
    a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd.go && !cmd.abort && !pop) |=> $stable(drain_left));
endmodule

// File: rtl/ird_ctrl.sv
module ird_ctrl
    import ird_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [2:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        win_rd,
    output logic [31:0] win_data,
    input  logic        src_valid,
    input  logic [31:0] src_data,
    output logic        src_ready,
    output logic [31:0] fl_addr
);
    reg_sel_e         sel;
    ctl_cmd_t         cmd;
    logic [REG_W-1:0] count_q, addr_q, push_data;
    logic [LW-1:0]    part_q, level;
    logic             busy, done, push, pop, flush, wr_ctl;

    assign sel          = reg_sel_e'(host_sel);
    assign wr_ctl       = host_we && (sel == SEL_CTRL);
    assign cmd.go       = wr_ctl && host_wdata[CTL_GO];
    assign cmd.abort    = wr_ctl && host_wdata[CTL_ABORT];
    assign cmd.ack_done = wr_ctl && host_wdata[CTL_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            addr_q  <= '0;
            part_q  <= LW'(DEPTH / 2);
        end else if (host_we) begin
            case (sel)
                SEL_COUNT: count_q <= host_wdata;
                SEL_ADDR:  addr_q  <= host_wdata;
                SEL_PART:  part_q  <= (host_wdata > REG_W'(DEPTH)) ? LW'(DEPTH)
                                                                   : host_wdata[LW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        host_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                host_rdata[CTL_BUSY] = busy;
                host_rdata[CTL_DONE] = done;
            end
            SEL_COUNT: host_rdata = count_q;
            SEL_ADDR:  host_rdata = addr_q;
            SEL_LEVEL: host_rdata = REG_W'(level);
            SEL_PART:  host_rdata = REG_W'(part_q);
            default:   host_rdata = '0;
        endcase
    end

    ird_seq #(.LW(LW)) u_seq (
        .clk(clk), .rst(rst), .cmd(cmd), .count_q(count_q), .addr_q(addr_q),
        .level(level), .part(part_q), .src_valid(src_valid), .src_data(src_data),
        .win_rd(win_rd), .busy(busy), .done(done), .src_ready(src_ready),
        .fl_addr(fl_addr), .push(push), .push_data(push_data), .pop(pop), .flush(flush)
    );

    ird_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .wdata(push_data),
        .pop(pop), .rdata(win_data), .level(level)
    );

    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));
endmodule

// File: tb/sim_ird_ctrl.sv
module sim_ird_ctrl;
    import ird_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        win_rd = 1'b0;
    logic [31:0] win_data;
    logic        src_valid = 1'b0;
    logic [31:0] src_data;
    logic        src_ready;
    logic [31:0] fl_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // source model: each byte carries the low 8 bits of its own flash address
    assign src_data = {fl_addr[7:0] + 8'd3, fl_addr[7:0] + 8'd2,
                       fl_addr[7:0] + 8'd1, fl_addr[7:0]};

    ird_ctrl u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .win_rd(win_rd),
        .win_data(win_data), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .fl_addr(fl_addr)
    );

    // stimulus table: {start address, byte count, expected words}
    localparam logic [95:0] VEC [5] = '{
        {32'h0000_0100, 32'd16, 32'd4},
        {32'h0000_02F0, 32'd5,  32'd2},
        {32'h0000_0040, 32'd3,  32'd1},
        {32'h0000_1000, 32'd1,  32'd1},
        {32'h0000_077C, 32'd34, 32'd9}
    };

    function automatic logic [31:0] exp_word(input logic [31:0] a, input int left);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = (b < left) ? (a[7:0] + 8'(b)) : 8'h00;
        return r;
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input reg_sel_e s, output logic [31:0] d);
        host_sel = s;
        #1;
        d = host_rdata;
    endtask

    task automatic reg_write(input reg_sel_e s, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_level();
        logic [31:0] d;
        rd(SEL_LEVEL, d);
        for (int k = 0; k < 300 && d[15:0] == 16'd0; k++) begin
            @(negedge clk);
            rd(SEL_LEVEL, d);
        end
        if (d[15:0] == 16'd0) check_eq("R3 data never arrived", d, 32'd1);
    endtask

    task automatic pop_one(input string req, input logic [31:0] exp);
        check_eq(req, win_data, exp);
        win_rd = 1'b1;
        @(negedge clk);
        win_rd = 1'b0;
    endtask

    task automatic drain_words(input logic [31:0] a, input int cnt, input int first);
        int nw = (cnt + 3) / 4;
        for (int i = first; i < nw; i++) begin
            wait_level();
            pop_one((cnt % 4 != 0 && i == nw - 1) ? "R6 padded last word" : "R5 word order",
                    exp_word(a + 32'(4 * i), cnt - 4 * i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(SEL_CTRL, d);  check_eq("R1 ctrl", d, 32'h0);
        rd(SEL_LEVEL, d); check_eq("R1 level", d, 32'h0);
        rd(SEL_PART, d);  check_eq("R1 partition", d, 32'd8);
        check_eq("R1 src_ready", 32'(src_ready), 32'd0);

        // table-driven transfers
        for (int v = 0; v < 5; v++) begin
            logic [31:0] va, vc, vn;
            va = VEC[v][95:64]; vc = VEC[v][63:32]; vn = VEC[v][31:0];
            src_valid = 1'b1;
            reg_write(SEL_COUNT, vc);
            reg_write(SEL_ADDR, va);
            reg_write(SEL_CTRL, 32'h1);
            rd(SEL_CTRL, d); check_eq("R2 in progress after start", d, 32'h4);
            drain_words(va, int'(vc), 0);
            rd(SEL_CTRL, d); check_eq("R8 done after last word", d, 32'h20);
            check_eq("R3 fetch stopped", 32'(src_ready), 32'd0);
            check_eq("R3 final address", fl_addr, va + 4 * vn);
            repeat (3) @(negedge clk);
            rd(SEL_CTRL, d); check_eq("R8 done sticky", d, 32'h20);
            reg_write(SEL_CTRL, 32'h20);
            rd(SEL_CTRL, d); check_eq("R8 done cleared", d, 32'h0);
        end

        // R7 partition stall and resume
        reg_write(SEL_COUNT, 32'd64);
        reg_write(SEL_ADDR, 32'h200);
        reg_write(SEL_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        rd(SEL_LEVEL, d); check_eq("R7 level capped at partition", d, 32'd8);
        check_eq("R7 src_ready low when full", 32'(src_ready), 32'd0);
        rd(SEL_LEVEL, d); check_eq("R4 write level zero", {16'h0, d[31:16]}, 32'h0);
        pop_one("R5 first word", exp_word(32'h200, 64));
        repeat (2) @(negedge clk);
        rd(SEL_LEVEL, d); check_eq("R7 refilled after space", d, 32'd8);
        reg_write(SEL_PART, 32'd12);
        repeat (6) @(negedge clk);
        rd(SEL_LEVEL, d); check_eq("R7 larger partition", d, 32'd12);
        drain_words(32'h200, 64, 1);
        reg_write(SEL_CTRL, 32'h20);
        reg_write(SEL_PART, 32'd100);
        rd(SEL_PART, d); check_eq("R7 partition clamp", d, 32'd16);
        reg_write(SEL_PART, 32'd8);

        // R5 take and removal in one cycle
        src_valid = 1'b0;
        reg_write(SEL_COUNT, 32'd32);
        reg_write(SEL_ADDR, 32'h300);
        reg_write(SEL_CTRL, 32'h1);
        src_valid = 1'b1;
        repeat (3) @(negedge clk);
        src_valid = 1'b0;
        rd(SEL_LEVEL, d); check_eq("R3 three words taken", d, 32'd3);
        src_valid = 1'b1;
        pop_one("R5 oldest word on overlap", exp_word(32'h300, 32));
        src_valid = 1'b0;
        rd(SEL_LEVEL, d); check_eq("R5 level unchanged on overlap", d, 32'd3);
        src_valid = 1'b1;
        drain_words(32'h300, 32, 1);

        // R8 set wins over clear (done still set from previous transfer)
        reg_write(SEL_COUNT, 32'd8);
        reg_write(SEL_ADDR, 32'h400);
        reg_write(SEL_CTRL, 32'h1);
        wait_level();
        pop_one("R5 word", exp_word(32'h400, 8));
        wait_level();
        check_eq("R5 last word", win_data, exp_word(32'h404, 4));
        win_rd = 1'b1; host_we = 1'b1; host_sel = SEL_CTRL; host_wdata = 32'h20;
        @(negedge clk);
        win_rd = 1'b0; host_we = 1'b0;
        rd(SEL_CTRL, d); check_eq("R8 set beats clear", d, 32'h20);
        reg_write(SEL_CTRL, 32'h20);

        // R9 cancel
        reg_write(SEL_COUNT, 32'd40);
        reg_write(SEL_ADDR, 32'h500);
        reg_write(SEL_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        reg_write(SEL_CTRL, 32'h2);
        rd(SEL_CTRL, d);  check_eq("R9 cancel clears busy, no done", d, 32'h0);
        rd(SEL_LEVEL, d); check_eq("R9 cancel empties buffer", d, 32'h0);
        check_eq("R9 src_ready after cancel", 32'(src_ready), 32'd0);
        repeat (3) @(negedge clk);
        rd(SEL_CTRL, d);  check_eq("R9 done stays clear", d, 32'h0);
        win_rd = 1'b1;
        @(negedge clk);
        win_rd = 1'b0;
        rd(SEL_LEVEL, d); check_eq("R5 empty pop ignored", d, 32'h0);
        reg_write(SEL_CTRL, 32'h3);
        rd(SEL_CTRL, d);  check_eq("R9 cancel beats start", d, 32'h0);
        check_eq("R9 no fetch after cancel+start", 32'(src_ready), 32'd0);

        // R10 start while busy
        src_valid = 1'b0;
        reg_write(SEL_COUNT, 32'd8);
        reg_write(SEL_ADDR, 32'h10);
        reg_write(SEL_CTRL, 32'h1);
        reg_write(SEL_COUNT, 32'd100);
        reg_write(SEL_ADDR, 32'h900);
        reg_write(SEL_CTRL, 32'h1);
        check_eq("R10 address kept", fl_addr, 32'h10);
        rd(SEL_CTRL, d); check_eq("R10 still in progress", d, 32'h4);
        src_valid = 1'b1;
        drain_words(32'h10, 8, 0);
        rd(SEL_CTRL, d); check_eq("R10 original count finished", d, 32'h20);
        reg_write(SEL_CTRL, 32'h20);

        // R11 zero count
        reg_write(SEL_COUNT, 32'd0);
        reg_write(SEL_CTRL, 32'h1);
        rd(SEL_CTRL, d); check_eq("R11 zero count done at once", d, 32'h20);
        check_eq("R11 no fetch", 32'(src_ready), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule